// File: doc/BRIEF.md
# Sleep-capable asynchronous serial receiver

This block receives asynchronous serial frames for a node on a shared multidrop line. The line is sampled at sixteen ticks per bit-time. A start bit is accepted only when the vote taken around its middle is low. Eight data bits arrive LSB first, followed by one stop bit. The assembled word goes to a data register, a full flag is raised, and a low stop bit raises a framing-error flag.

Software can put the receiver to sleep after it sees a frame that is not meant for this node. While asleep, the receiver still follows the line, but frames do not update the data register and the status outputs read zero. Hardware ends the sleep in one of two ways, chosen by a mode input:
- **Idle mode:** a run of idle line one full frame long wakes the receiver.
- **Address mode:** a frame whose MSB is set wakes the receiver, and that frame is delivered.

A loop control feeds the local transmitter's serial output straight into the receiver and holds the outgoing pin idle.

Top module: `sleepy_uart_rx`

## Requirements
- R1: With `osTick` high every cycle, a frame is delivered after its stop bit is sampled. The frame is a low start bit, 8 data bits sent LSB first, and a stop bit, each bit lasting 16 ticks. On delivery, `rxData` holds the word and `rxFull` reads 1.
- R2: Each bit is decided by a majority vote of ticks 7, 8 and 9 counted from the bit's leading edge. A low pulse shorter than the vote window does not start a frame, so nothing is delivered.
- R3: A delivered frame whose stop-bit vote is low sets `frameErr` together with `rxFull`.
- R4: A one-cycle `readStrobe` clears both `rxFull` and `frameErr` on the next clock.
- R5: `sleepSet` makes `asleep` read 1 and `sleepClr` makes it read 0. While asleep, `rxFull` and `frameErr` read 0, and frames that do not wake the block leave `rxData` unchanged. A flag pending before sleep shows again once the block is awake.
- R6: With `wakeOnAddr` = 0, a sleeping block clears `asleep` once the line has stayed high for 160 consecutive ticks. The count restarts at any low sample and at `sleepSet`. The next frame is then delivered normally.
- R7: With `wakeOnAddr` = 1, a sleeping block ignores idle time and frames whose MSB (last data bit) is 0. A frame whose MSB is 1 clears `asleep` and is itself delivered, with `frameErr` set if its stop bit was low.
- R8: With `loopEn` = 1, the receiver takes its input from `txSerial`, `rxPin` has no effect, and `txPin` is held at 1. With `loopEn` = 0, `txPin` follows `txSerial`.
- R9: When `sleepSet` and `sleepClr` are pulsed in the same cycle, `asleep` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| osTick | input | 1 | Oversample tick, 16 per bit-time |
| rxPin | input | 1 | Serial line from the pin |
| txSerial | input | 1 | Serial output of the local transmitter |
| loopEn | input | 1 | 1 = loop transmitter output into the receiver |
| wakeOnAddr | input | 1 | Wake mode: 0 idle line, 1 address mark |
| sleepSet | input | 1 | Pulse: enter sleep |
| sleepClr | input | 1 | Pulse: leave sleep by software |
| readStrobe | input | 1 | Pulse: data register read, clears flags |
| rxData | output | 8 | Last delivered data word |
| rxFull | output | 1 | Data register full (masked while asleep) |
| frameErr | output | 1 | Last delivered frame had a low stop bit (masked while asleep) |
| asleep | output | 1 | Sleep state |
| txPin | output | 1 | Serial line to the pin |

## Verification
Faults show up at different times, and the checks are placed to catch each one:
- **Phase or bit counter:** a corrupted count only shows about ten bit-times later, as a wrong `rxData` or a false `frameErr` when the stop bit is voted. Every frame check therefore samples two bit-times after the stop bit.
- **Sleep bit:** a wrong value shows on `asleep` and on the masked flags within one cycle.
- **Idle counter:** an error is visible only around the 160-tick boundary, so the line is probed at 144 and at 176 ticks of idle.
- **Suppression while asleep:** a leak would show only as a changed `rxData` after an ignored frame, so each ignored frame is followed by a readback of the previously delivered word.

// File: rtl/sleepy_rx_pkg.sv
package sleepy_rx_pkg;

  // receive sequencer states
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cap7;     // latch first vote sample
    logic cap8;     // latch second vote sample
    logic shiftIn;  // shift the voted bit into the word
    logic loadData; // copy the word to the data register
    logic idleRst;  // restart the idle run counter
  } rxStrobes_t;

endpackage

// File: rtl/sleepy_rx_datapath.sv
module sleepy_rx_datapath
  import sleepy_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 osTick,
  input  logic                 rxPin,
  input  logic                 txSerial,
  input  logic                 loopEn,
  input  rxStrobes_t           strb,
  output logic                 lineBit,
  output logic                 vote,
  output logic                 shiftMsb,
  output logic                 idleSeen,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 txPin
);

  localparam int IDLE_TICKS = (DATA_BITS + 2) * OVERSAMPLE;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);

  logic                 rxSource;
  logic [1:0]           syncQ;
  logic                 samp7, samp8;
  logic [DATA_BITS-1:0] shiftReg;
  logic [IDLE_W-1:0]    idleCnt;

  // loop path: receiver listens to the transmitter, pin stays idle
  assign rxSource = loopEn ? txSerial : rxPin;
  assign txPin    = loopEn ? 1'b1 : txSerial;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxSource};
  end
  assign lineBit = syncQ[1];

  // three-sample majority; the third sample is the live one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samp7 <= 1'b1;
      samp8 <= 1'b1;
    end else begin
      if (strb.cap7) samp7 <= lineBit;
      if (strb.cap8) samp8 <= lineBit;
    end
  end
  assign vote = (samp7 & samp8) | (samp7 & lineBit) | (samp8 & lineBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
    end else begin
      if (strb.shiftIn)  shiftReg <= {vote, shiftReg[DATA_BITS-1:1]};
      if (strb.loadData) rxData   <= shiftReg;
    end
  end
  assign shiftMsb = shiftReg[DATA_BITS-1];

  // consecutive high ticks, saturating at one frame length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strb.idleRst) begin
      idleCnt <= '0;
    end else if (osTick) begin
      if (!lineBit)                           idleCnt <= '0;
      else if (idleCnt != IDLE_W'(IDLE_TICKS)) idleCnt <= idleCnt + IDLE_W'(1);
    end
  end
  assign idleSeen = (idleCnt == IDLE_W'(IDLE_TICKS));

endmodule

// File: rtl/sleepy_rx_control.sv
module sleepy_rx_control
  import sleepy_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       osTick,
  input  logic       lineBit,
  input  logic       vote,
  input  logic       shiftMsb,
  input  logic       idleSeen,
  input  logic       wakeOnAddr,
  input  logic       sleepSet,
  input  logic       sleepClr,
  input  logic       readStrobe,
  output rxStrobes_t strb,
  output logic       asleep,
  output logic       rxFull,
  output logic       frameErr
);

  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int MID   = OVERSAMPLE / 2;

  rxState_e   state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitCnt;
  logic sleepBit, fullBit, errBit;
  logic active, atVote, atWrap, frameDone, wakeAddr, wakeIdle;

  always_comb begin
    active    = (state != ST_IDLE);
    atVote    = osTick && active && (phase == PH_W'(MID + 1));
    atWrap    = osTick && active && (phase == PH_W'(OVERSAMPLE - 1));
    frameDone = atVote && (state == ST_STOP);
    wakeAddr  = frameDone && sleepBit && wakeOnAddr && shiftMsb;
    wakeIdle  = sleepBit && !wakeOnAddr && idleSeen;
    strb.cap7     = osTick && active && (phase == PH_W'(MID - 1));
    strb.cap8     = osTick && active && (phase == PH_W'(MID));
    strb.shiftIn  = atVote && (state == ST_DATA);
    strb.loadData = frameDone && (!sleepBit || wakeAddr);
    strb.idleRst  = sleepSet || !sleepBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitCnt <= '0;
    end else if (osTick) begin
      case (state)
        ST_IDLE: begin
          if (!lineBit) begin
            state <= ST_START;
            phase <= PH_W'(1);
          end
        end
        ST_START: begin
          if (atVote && vote) begin
            state <= ST_IDLE;
            phase <= '0;
          end else if (atWrap) begin
            state  <= ST_DATA;
            bitCnt <= '0;
            phase  <= '0;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ST_DATA: begin
          if (atWrap) begin
            phase <= '0;
            if (bitCnt == BIT_W'(DATA_BITS - 1)) state <= ST_STOP;
            else                                 bitCnt <= bitCnt + BIT_W'(1);
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ST_STOP: begin
          if (atVote) begin
            state <= ST_IDLE;
            phase <= '0;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          phase <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepBit <= 1'b0;
      fullBit  <= 1'b0;
      errBit   <= 1'b0;
    end else begin
      if (sleepSet)                 sleepBit <= 1'b1;
      else if (sleepClr)            sleepBit <= 1'b0;
      else if (wakeAddr || wakeIdle) sleepBit <= 1'b0;

      if (strb.loadData) begin
        fullBit <= 1'b1;
        errBit  <= !vote;
      end else if (readStrobe) begin
        fullBit <= 1'b0;
        errBit  <= 1'b0;
      end
    end
  end

  assign asleep   = sleepBit;
  assign rxFull   = fullBit & ~sleepBit;
  assign frameErr = errBit & ~sleepBit;

endmodule

// File: rtl/sleepy_uart_rx.sv
module sleepy_uart_rx
  import sleepy_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 osTick,
  input  logic                 rxPin,
  input  logic                 txSerial,
  input  logic                 loopEn,
  input  logic                 wakeOnAddr,
  input  logic                 sleepSet,
  input  logic                 sleepClr,
  input  logic                 readStrobe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 frameErr,
  output logic                 asleep,
  output logic                 txPin
);

  rxStrobes_t strb;
  logic lineBit, vote, shiftMsb, idleSeen;

  sleepy_rx_datapath #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_dp (
    .clk(clk), .rstN(rstN), .osTick(osTick), .rxPin(rxPin),
    .txSerial(txSerial), .loopEn(loopEn), .strb(strb),
    .lineBit(lineBit), .vote(vote), .shiftMsb(shiftMsb),
    .idleSeen(idleSeen), .rxData(rxData), .txPin(txPin)
  );

  sleepy_rx_control #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .osTick(osTick), .lineBit(lineBit),
    .vote(vote), .shiftMsb(shiftMsb), .idleSeen(idleSeen),
    .wakeOnAddr(wakeOnAddr), .sleepSet(sleepSet), .sleepClr(sleepClr),
    .readStrobe(readStrobe), .strb(strb), .asleep(asleep),
    .rxFull(rxFull), .frameErr(frameErr)
  );

endmodule

// File: rtl/sleepy_uart_rx_chk.sv
module sleepy_uart_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sleepSet,
  input logic                 sleepClr,
  input logic                 readStrobe,
  input logic                 wakeOnAddr,
  input logic                 asleep,
  input logic                 rxFull,
  input logic                 frameErr,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 loadData,
  input logic                 idleSeen,
  input logic                 shiftMsb
);

  assert_err_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> rxFull);

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !loadData) |=> (!rxFull && !frameErr));

  assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sleepClr && !sleepSet) |=> !asleep);

  assert_frozen_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && $past(asleep)) |-> $stable(rxData));

  assert_idle_wake_R6: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !wakeOnAddr && idleSeen && !sleepSet) |=> !asleep);

  assert_addr_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && loadData) |-> (wakeOnAddr && shiftMsb));

  assert_addr_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && loadData && !sleepSet) |=> (!asleep && rxFull));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleepSet |=> asleep);

endmodule

bind sleepy_uart_rx sleepy_uart_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sleepSet(sleepSet), .sleepClr(sleepClr),
  .readStrobe(readStrobe), .wakeOnAddr(wakeOnAddr), .asleep(asleep),
  .rxFull(rxFull), .frameErr(frameErr), .rxData(rxData),
  .loadData(strb.loadData), .idleSeen(idleSeen), .shiftMsb(shiftMsb)
);

// File: tb/sleepy_uart_rx_tb.sv
module sleepy_uart_rx_tb;

  localparam int BITC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic osTick = 1'b1;
  logic rxPin = 1'b1;
  logic txSerial = 1'b1;
  logic loopEn = 1'b0;
  logic wakeOnAddr = 1'b0;
  logic sleepSet = 1'b0;
  logic sleepClr = 1'b0;
  logic readStrobe = 1'b0;
  logic [7:0] rxData;
  logic rxFull, frameErr, asleep, txPin;
  logic useLoop = 1'b0;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  sleepy_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .osTick(osTick), .rxPin(rxPin),
    .txSerial(txSerial), .loopEn(loopEn), .wakeOnAddr(wakeOnAddr),
    .sleepSet(sleepSet), .sleepClr(sleepClr), .readStrobe(readStrobe),
    .rxData(rxData), .rxFull(rxFull), .frameErr(frameErr),
    .asleep(asleep), .txPin(txPin)
  );

  typedef struct packed {
    logic       sleepFirst;
    logic       mode;
    logic [4:0] gapBits;
    logic [7:0] data;
    logic       stopBit;
    logic       expFull;
    logic [7:0] expData;
    logic       expErr;
    logic       expAsleep;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 5'd2,  8'h3C, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0}, // R1 plain
    '{1'b0, 1'b0, 5'd2,  8'hA5, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0}, // R3 low stop
    '{1'b1, 1'b0, 5'd0,  8'h11, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1}, // R5 ignored
    '{1'b1, 1'b0, 5'd12, 8'h42, 1'b1, 1'b1, 8'h42, 1'b0, 1'b0}, // R6 woke
    '{1'b1, 1'b0, 5'd8,  8'h0F, 1'b1, 1'b0, 8'h42, 1'b0, 1'b1}, // R6 short gap
    '{1'b1, 1'b1, 5'd12, 8'h35, 1'b1, 1'b0, 8'h42, 1'b0, 1'b1}, // R7 idle ignored
    '{1'b1, 1'b1, 5'd0,  8'hB7, 1'b1, 1'b1, 8'hB7, 1'b0, 1'b0}, // R7 address
    '{1'b1, 1'b1, 5'd3,  8'h81, 1'b0, 1'b1, 8'h81, 1'b1, 1'b0}, // R7 address err
    '{1'b0, 1'b1, 5'd1,  8'h22, 1'b1, 1'b1, 8'h22, 1'b0, 1'b0}, // R1 awake mode1
    '{1'b1, 1'b1, 5'd0,  8'h7F, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1}, // R5 no err asleep
    '{1'b1, 1'b0, 5'd0,  8'hC3, 1'b1, 1'b0, 8'h22, 1'b0, 1'b1}  // R5 ignored
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic b, input int cycles);
    if (useLoop) txSerial = b;
    else         rxPin = b;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic stopB);
    drive(1'b0, BITC);
    for (int i = 0; i < 8; i++) drive(d[i], BITC);
    drive(stopB, BITC);
    drive(1'b1, 2 * BITC);
  endtask

  task automatic pulseRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic pulseSleep(input logic setIt, input logic clrIt);
    sleepSet = setIt;
    sleepClr = clrIt;
    @(negedge clk);
    sleepSet = 1'b0;
    sleepClr = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R1", "reset rxFull", rxFull, 0);
    check("R3", "reset frameErr", frameErr, 0);
    check("R5", "reset asleep", asleep, 0);
    check("R1", "reset rxData", rxData, 0);
    check("R8", "reset txPin", txPin, 1);

    for (int v = 0; v < NVEC; v++) begin
      pulseRead();
      wakeOnAddr = VECS[v].mode;
      if (VECS[v].sleepFirst) pulseSleep(1'b1, 1'b0);
      else                    pulseSleep(1'b0, 1'b1);
      drive(1'b1, VECS[v].gapBits * BITC);
      sendFrame(VECS[v].data, VECS[v].stopBit);
      check("R1/R5/R7", $sformatf("vec%0d rxFull", v), rxFull, VECS[v].expFull);
      check("R1/R5/R7", $sformatf("vec%0d rxData", v), rxData, VECS[v].expData);
      check("R3/R7", $sformatf("vec%0d frameErr", v), frameErr, VECS[v].expErr);
      check("R6/R7", $sformatf("vec%0d asleep", v), asleep, VECS[v].expAsleep);
    end

    // R4 read clears the full flag
    pulseSleep(1'b0, 1'b1);
    wakeOnAddr = 1'b0;
    pulseRead();
    sendFrame(8'h5A, 1'b1);
    check("R1", "rxData 5A", rxData, 8'h5A);
    pulseRead();
    check("R4", "rxFull after read", rxFull, 0);

    // R5 pending flag hidden while asleep, shown again after clear
    sendFrame(8'h66, 1'b1);
    check("R1", "rxFull 66", rxFull, 1);
    pulseSleep(1'b1, 1'b0);
    check("R5", "rxFull masked", rxFull, 0);
    pulseSleep(1'b0, 1'b1);
    check("R5", "rxFull back", rxFull, 1);
    check("R5", "rxData kept", rxData, 8'h66);

    // R3 / R4 framing error and its clear
    pulseRead();
    sendFrame(8'h10, 1'b0);
    check("R3", "frameErr set", frameErr, 1);
    pulseRead();
    check("R4", "frameErr cleared", frameErr, 0);

    // R2 short low glitch is no start bit
    drive(1'b0, 4);
    drive(1'b1, 12 * BITC);
    check("R2", "glitch rxFull", rxFull, 0);
    check("R2", "glitch rxData", rxData, 8'h10);

    // R8 loop path
    txSerial = 1'b0;
    @(negedge clk);
    check("R8", "txPin follows", txPin, 0);
    txSerial = 1'b1;
    loopEn = 1'b1;
    @(negedge clk);
    rxPin = 1'b0;
    useLoop = 1'b1;
    txSerial = 1'b0;
    @(negedge clk);
    check("R8", "txPin held idle", txPin, 1);
    sendFrame(8'h9C, 1'b1);
    check("R8", "loop rxData", rxData, 8'h9C);
    check("R8", "loop rxFull", rxFull, 1);
    useLoop = 1'b0;
    rxPin = 1'b1;
    @(negedge clk);
    loopEn = 1'b0;
    repeat (4) @(negedge clk);

    // R9 set wins, R6 idle boundary
    wakeOnAddr = 1'b0;
    pulseSleep(1'b1, 1'b1);
    check("R9", "set wins", asleep, 1);
    drive(1'b1, 9 * BITC);
    check("R6", "asleep at 144 ticks", asleep, 1);
    drive(1'b1, 2 * BITC);
    check("R6", "awake at 176 ticks", asleep, 0);

    finishRun();
  end

endmodule